// File: doc/BRIEF.md
# Write-Protection Command Gate

This block sits between the byte-load path and the sector program controller of a page-programmed flash array. Every byte load (address and data) passes through it. The gate watches the loads for two fixed command sequences: a three-load unlock sequence and a six-load disable sequence. Loads that advance a sequence are consumed as commands. All other loads are forwarded one clock later to the sector load buffer.

The gate keeps a protection flag. Only a separate non-volatile reset input touches this flag, so the flag models a setting that survives power cycles. The ordinary reset leaves it alone. Once the flag is set, each program cycle commits only if the unlock sequence arrived since the previous cycle opened. Otherwise the commit-allow output stays low for the whole cycle. The program controller still runs its timer and polling for that cycle; it simply writes nothing. One protection flag covers every sector. The command sequences are module parameters.

The program controller frames each program cycle with a start pulse, raised when the per-byte load window expires, and a done pulse, raised when its timer ends. Because sequence tracking clears on each of these pulses, command loads obey the same load window as ordinary sector data.

Top module: `wr_protect_gate`

## Requirements
- R1: An active-low `nvRstN` clears `protectOn` to 0, which is the delivered state. Nothing else clears it except a completed disable sequence.
- R2: While `protectOn` is 0, every program cycle commits. `commitAllow` rises on the clock after an accepted `cycleStart` and falls on the clock after `cycleDone`. It never rises without a start.
- R3: The default unlock sequence is three loads: step 0 is address 05555h with data AAh, step 1 is 02AAAh with 55h, and step 2 is 05555h with A0h. When it completes, `protectOn` becomes 1 on the clock after the third load, and the next program cycle commits.
- R4: While `protectOn` is 1, a program cycle that was not preceded by a complete unlock sequence keeps `commitAllow` at 0 from its start through its done. The cycle itself is still framed normally.
- R5: A completed unlock sequence permits exactly one program cycle. The cycle after it is blocked again.
- R6: The default disable sequence is six loads: 05555h/AAh, 02AAAh/55h, 05555h/80h, 05555h/AAh, 02AAAh/55h, 05555h/20h. When it completes, `protectOn` clears on the clock after the sixth load.
- R7: A load that advances either sequence is consumed and not forwarded. Any other load accepted while no cycle is open appears on `fwdValid`/`fwdAddr`/`fwdData` one clock later.
- R8: A load that matches neither tracker's expected step resets both trackers and is forwarded as sector data, even if it matches step 0. A complete sequence must then be given again.
- R9: An accepted `cycleStart` or `cycleDone` discards a partly received sequence.
- R10: Loads between an accepted `cycleStart` and the matching `cycleDone`, including a load in the same clock as `cycleStart` or `cycleDone`, are neither forwarded nor tracked.
- R11: The ordinary `rstN` clears sequence tracking, the one-cycle unlock permission, the open-cycle state and the outputs other than `protectOn`. It leaves `protectOn` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Ordinary synchronous reset, active low |
| nvRstN | input | 1 | Synchronous reset of the persistent protection flag, active low |
| loadValid | input | 1 | One-clock byte-load event |
| loadAddr | input | ADDR_W | Byte-load address |
| loadData | input | DATA_W | Byte-load data |
| cycleStart | input | 1 | Program controller opens a program cycle |
| cycleDone | input | 1 | Program controller ends the program cycle |
| fwdValid | output | 1 | Forwarded sector-data load is valid |
| fwdAddr | output | ADDR_W | Forwarded load address |
| fwdData | output | DATA_W | Forwarded load data |
| commitAllow | output | 1 | The open program cycle may write the array |
| protectOn | output | 1 | Write protection is enabled |

## Verification
The bench builds the gate with its default parameters: a 19-bit address, 8-bit data, and the three-step unlock and six-step disable sequences listed above. These sequences share their first two steps, so the bench can drive a load that advances both trackers at once. It can also check that the third step decides between unlocking and the disable branch, and that a stray byte after a shared prefix resets both trackers. The short default lengths let every step position, every completion and every abort be reached within a few dozen loads.

// File: rtl/wr_protect_pkg.sv
package wr_protect_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic trackEn;     // a load is accepted for tracking/forwarding
    logic clearSeq;    // discard any partial sequence
    logic openCycle;   // program cycle accepted: decide commit
    logic closeCycle;  // program cycle finished
  } gateStrobe_t;

  typedef enum logic [0:0] {
    GATE_IDLE = 1'b0,
    GATE_BUSY = 1'b1
  } gateState_t;

endpackage

// File: rtl/wr_protect_seq.sv
module wr_protect_seq #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int LEN    = 3,
  // index i holds step i of the sequence
  parameter logic [LEN-1:0][ADDR_W-1:0] SEQ_ADDR = '0,
  parameter logic [LEN-1:0][DATA_W-1:0] SEQ_DATA = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              clear,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              stepHit,
  output logic              seqDone
);

  localparam int POS_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LEN - 1);

  logic [POS_W-1:0] pos;
  logic [LEN-1:0]   stepMatch;
  logic             expectMatch;

  for (genvar i = 0; i < LEN; i++) begin : g_step
    assign stepMatch[i] = (loadAddr == SEQ_ADDR[i]) && (loadData == SEQ_DATA[i]);
  end

  always_comb begin
    expectMatch = 1'b0;
    for (int i = 0; i < LEN; i++) begin
      if (pos == POS_W'(i)) expectMatch = stepMatch[i];
    end
  end

  assign stepHit = loadEn && expectMatch;
  assign seqDone = stepHit && (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= '0;
    end else if (clear) begin
      pos <= '0;
    end else if (loadEn) begin
      if (seqDone || !stepHit) pos <= '0;
      else                     pos <= pos + POS_W'(1);
    end
  end

endmodule

// File: rtl/wr_protect_ctrl.sv
module wr_protect_ctrl
  import wr_protect_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadValid,
  input  logic        cycleStart,
  input  logic        cycleDone,
  output gateStrobe_t strobe,
  output logic        cycleOpen
);

  gateState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      GATE_IDLE: begin
        if (cycleStart) begin
          strobe.openCycle = 1'b1;
          strobe.clearSeq  = 1'b1;
          stateNext        = GATE_BUSY;
        end else if (loadValid) begin
          strobe.trackEn = 1'b1;
        end
      end
      GATE_BUSY: begin
        if (cycleDone) begin
          strobe.closeCycle = 1'b1;
          strobe.clearSeq   = 1'b1;
          stateNext         = GATE_IDLE;
        end
      end
      default: stateNext = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= GATE_IDLE;
    else       state <= stateNext;
  end

  assign cycleOpen = (state == GATE_BUSY);

endmodule

// File: rtl/wr_protect_dp.sv
module wr_protect_dp
  import wr_protect_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int UNLOCK_LEN  = 3,
  parameter int DISABLE_LEN = 6,
  parameter logic [UNLOCK_LEN-1:0][ADDR_W-1:0]  UNLOCK_ADDR  = '0,
  parameter logic [UNLOCK_LEN-1:0][DATA_W-1:0]  UNLOCK_DATA  = '0,
  parameter logic [DISABLE_LEN-1:0][ADDR_W-1:0] DISABLE_ADDR = '0,
  parameter logic [DISABLE_LEN-1:0][DATA_W-1:0] DISABLE_DATA = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvRstN,
  input  gateStrobe_t       strobe,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              commitAllow,
  output logic              protectOn
);

  logic unlockHit, unlockDone;
  logic disableHit, disableDone;
  logic seqClear;
  logic armedQ;

  // any completion restarts both trackers
  assign seqClear = strobe.clearSeq || unlockDone || disableDone;

  wr_protect_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN(UNLOCK_LEN),
    .SEQ_ADDR(UNLOCK_ADDR), .SEQ_DATA(UNLOCK_DATA)
  ) u_unlockSeq (
    .clk(clk), .rstN(rstN), .loadEn(strobe.trackEn), .clear(seqClear),
    .loadAddr(loadAddr), .loadData(loadData),
    .stepHit(unlockHit), .seqDone(unlockDone)
  );

  wr_protect_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN(DISABLE_LEN),
    .SEQ_ADDR(DISABLE_ADDR), .SEQ_DATA(DISABLE_DATA)
  ) u_disableSeq (
    .clk(clk), .rstN(rstN), .loadEn(strobe.trackEn), .clear(seqClear),
    .loadAddr(loadAddr), .loadData(loadData),
    .stepHit(disableHit), .seqDone(disableDone)
  );

  // persistent flag: only the non-volatile reset clears it
  always_ff @(posedge clk) begin
    if (!nvRstN)                    protectOn <= 1'b0;
    else if (rstN && disableDone)   protectOn <= 1'b0;
    else if (rstN && unlockDone)    protectOn <= 1'b1;
  end

  // one-shot permission for the next program cycle
  always_ff @(posedge clk) begin
    if (!rstN)                 armedQ <= 1'b0;
    else if (strobe.openCycle) armedQ <= 1'b0;
    else if (unlockDone)       armedQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  commitAllow <= 1'b0;
    else if (strobe.openCycle)  commitAllow <= !protectOn || armedQ;
    else if (strobe.closeCycle) commitAllow <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
      fwdData  <= '0;
    end else begin
      fwdValid <= strobe.trackEn && !unlockHit && !disableHit;
      if (strobe.trackEn) begin
        fwdAddr <= loadAddr;
        fwdData <= loadData;
      end
    end
  end

endmodule

// File: rtl/wr_protect_gate.sv
module wr_protect_gate
  import wr_protect_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int UNLOCK_LEN  = 3,
  parameter int DISABLE_LEN = 6,
  // packed concatenations list the last step first
  parameter logic [UNLOCK_LEN-1:0][ADDR_W-1:0]  UNLOCK_ADDR  =
    {19'h05555, 19'h02AAA, 19'h05555},
  parameter logic [UNLOCK_LEN-1:0][DATA_W-1:0]  UNLOCK_DATA  =
    {8'hA0, 8'h55, 8'hAA},
  parameter logic [DISABLE_LEN-1:0][ADDR_W-1:0] DISABLE_ADDR =
    {19'h05555, 19'h02AAA, 19'h05555, 19'h05555, 19'h02AAA, 19'h05555},
  parameter logic [DISABLE_LEN-1:0][DATA_W-1:0] DISABLE_DATA =
    {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvRstN,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic              cycleStart,
  input  logic              cycleDone,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              commitAllow,
  output logic              protectOn
);

  gateStrobe_t strobe;
  logic        cycleOpen;

  wr_protect_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid),
    .cycleStart(cycleStart), .cycleDone(cycleDone),
    .strobe(strobe), .cycleOpen(cycleOpen)
  );

  wr_protect_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .UNLOCK_LEN(UNLOCK_LEN), .DISABLE_LEN(DISABLE_LEN),
    .UNLOCK_ADDR(UNLOCK_ADDR), .UNLOCK_DATA(UNLOCK_DATA),
    .DISABLE_ADDR(DISABLE_ADDR), .DISABLE_DATA(DISABLE_DATA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .nvRstN(nvRstN), .strobe(strobe),
    .loadAddr(loadAddr), .loadData(loadData),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr), .fwdData(fwdData),
    .commitAllow(commitAllow), .protectOn(protectOn)
  );

endmodule

// File: rtl/wr_protect_gate_chk.sv
module wr_protect_gate_chk (
  input logic clk,
  input logic rstN,
  input logic nvRstN,
  input logic loadValid,
  input logic cycleStart,
  input logic cycleOpen,
  input logic fwdValid,
  input logic commitAllow,
  input logic protectOn
);

  assert_nv_reset_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    !nvRstN |=> !protectOn);

  assert_commit_needs_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitAllow) |-> ($past(cycleStart) && !$past(cycleOpen)));

  assert_enable_from_load_R3: assert property (@(posedge clk) disable iff (!rstN || !nvRstN)
    $rose(protectOn) |-> ($past(loadValid) && !$past(cycleOpen)));

  assert_commit_within_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    commitAllow |-> cycleOpen);

  assert_disable_from_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectOn) |-> ($past(loadValid) || !$past(nvRstN)));

  assert_fwd_from_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> $past(loadValid));

  assert_busy_load_dropped_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(cycleOpen) |-> !fwdValid);

  assert_rst_keeps_flag_R11: assert property (@(posedge clk) disable iff (!nvRstN)
    (!rstN && nvRstN) |=> $stable(protectOn));

endmodule

bind wr_protect_gate wr_protect_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .nvRstN(nvRstN), .loadValid(loadValid),
  .cycleStart(cycleStart), .cycleOpen(cycleOpen), .fwdValid(fwdValid),
  .commitAllow(commitAllow), .protectOn(protectOn)
);

// File: tb/wr_protect_gate_bench.sv
`timescale 1ns/1ps
module wr_protect_gate_bench;

  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam logic [1:0] OP_LOAD = 2'd0, OP_START = 2'd1, OP_DONE = 2'd2, OP_BOTH = 2'd3;
  localparam int NVEC = 42;

  // {op, addr, data, expFwd/expProt/expCommit, requirement}
  localparam logic [35:0] VEC [NVEC] = '{
    {OP_START, 19'h00000, 8'h00, 3'b001, 4'd2},  // R2 unprotected cycle commits
    {OP_DONE,  19'h00000, 8'h00, 3'b000, 4'd2},
    {OP_LOAD,  19'h00100, 8'h12, 3'b100, 4'd7},  // R7 plain data forwarded
    {OP_LOAD,  19'h05555, 8'hAA, 3'b000, 4'd7},  // R7 command consumed
    {OP_LOAD,  19'h02AAA, 8'h55, 3'b000, 4'd7},
    {OP_LOAD,  19'h05555, 8'hA0, 3'b010, 4'd3},  // R3 enable
    {OP_LOAD,  19'h00200, 8'h34, 3'b110, 4'd7},
    {OP_START, 19'h00000, 8'h00, 3'b011, 4'd3},  // R3 armed cycle commits
    {OP_LOAD,  19'h00300, 8'h56, 3'b011, 4'd10}, // R10 load in cycle dropped
    {OP_DONE,  19'h00000, 8'h00, 3'b010, 4'd3},
    {OP_LOAD,  19'h00201, 8'h77, 3'b110, 4'd4},
    {OP_START, 19'h00000, 8'h00, 3'b010, 4'd4},  // R4 blocked cycle
    {OP_DONE,  19'h00000, 8'h00, 3'b010, 4'd4},
    {OP_LOAD,  19'h05555, 8'hAA, 3'b010, 4'd5},
    {OP_LOAD,  19'h02AAA, 8'h55, 3'b010, 4'd5},
    {OP_LOAD,  19'h05555, 8'hA0, 3'b010, 4'd5},
    {OP_START, 19'h00000, 8'h00, 3'b011, 4'd5},  // R5 one permitted cycle
    {OP_DONE,  19'h00000, 8'h00, 3'b010, 4'd5},
    {OP_START, 19'h00000, 8'h00, 3'b010, 4'd5},  // R5 next one blocked
    {OP_DONE,  19'h00000, 8'h00, 3'b010, 4'd5},
    {OP_LOAD,  19'h05555, 8'hAA, 3'b010, 4'd8},
    {OP_LOAD,  19'h02AAA, 8'h55, 3'b010, 4'd8},
    {OP_LOAD,  19'h05555, 8'h99, 3'b110, 4'd8},  // R8 mismatch forwarded
    {OP_LOAD,  19'h05555, 8'hA0, 3'b110, 4'd8},  // R8 tracking restarted
    {OP_START, 19'h00000, 8'h00, 3'b010, 4'd8},
    {OP_DONE,  19'h00000, 8'h00, 3'b010, 4'd8},
    {OP_LOAD,  19'h05555, 8'hAA, 3'b010, 4'd9},
    {OP_LOAD,  19'h02AAA, 8'h55, 3'b010, 4'd9},
    {OP_START, 19'h00000, 8'h00, 3'b010, 4'd9},  // R9 start breaks sequence
    {OP_DONE,  19'h00000, 8'h00, 3'b010, 4'd9},
    {OP_LOAD,  19'h05555, 8'hA0, 3'b110, 4'd9},
    {OP_START, 19'h00000, 8'h00, 3'b010, 4'd9},
    {OP_DONE,  19'h00000, 8'h00, 3'b010, 4'd9},
    {OP_LOAD,  19'h05555, 8'hAA, 3'b010, 4'd6},  // R6 disable sequence
    {OP_LOAD,  19'h02AAA, 8'h55, 3'b010, 4'd6},
    {OP_LOAD,  19'h05555, 8'h80, 3'b010, 4'd6},
    {OP_LOAD,  19'h05555, 8'hAA, 3'b010, 4'd6},
    {OP_LOAD,  19'h02AAA, 8'h55, 3'b010, 4'd6},
    {OP_LOAD,  19'h05555, 8'h20, 3'b000, 4'd6},
    {OP_START, 19'h00000, 8'h00, 3'b001, 4'd2},
    {OP_DONE,  19'h00000, 8'h00, 3'b000, 4'd2},
    {OP_LOAD,  19'h00400, 8'h9C, 3'b100, 4'd2}
  };

  logic clk = 1'b0;
  logic rstN, nvRstN, loadValid, cycleStart, cycleDone;
  logic [ADDR_W-1:0] loadAddr;
  logic [DATA_W-1:0] loadData;
  logic fwdValid, commitAllow, protectOn;
  logic [ADDR_W-1:0] fwdAddr;
  logic [DATA_W-1:0] fwdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wr_protect_gate u_wr_protect_gate (
    .clk(clk), .rstN(rstN), .nvRstN(nvRstN), .loadValid(loadValid),
    .loadAddr(loadAddr), .loadData(loadData), .cycleStart(cycleStart),
    .cycleDone(cycleDone), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .fwdData(fwdData), .commitAllow(commitAllow), .protectOn(protectOn)
  );

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one op for one clock, then sample outputs at the next falling edge
  task automatic runStep(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic eF, input logic eP, input logic eC, input int req);
    loadAddr   = a;
    loadData   = d;
    loadValid  = (op == OP_LOAD) || (op == OP_BOTH);
    cycleStart = (op == OP_START) || (op == OP_BOTH);
    cycleDone  = (op == OP_DONE);
    @(negedge clk);
    loadValid = 1'b0; cycleStart = 1'b0; cycleDone = 1'b0;
    check("fwdValid", req, 32'(fwdValid), 32'(eF));
    if (eF) begin
      check("fwdAddr", req, 32'(fwdAddr), 32'(a));
      check("fwdData", req, 32'(fwdData), 32'(d));
    end
    check("protectOn", req, 32'(protectOn), 32'(eP));
    check("commitAllow", req, 32'(commitAllow), 32'(eC));
  endtask

  initial begin
    rstN = 1'b0; nvRstN = 1'b0; loadValid = 1'b0; cycleStart = 1'b0; cycleDone = 1'b0;
    loadAddr = '0; loadData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; nvRstN = 1'b1;
    @(negedge clk);
    // R1 / R11 reset state
    check("reset protectOn", 1, 32'(protectOn), 32'd0);
    check("reset commitAllow", 11, 32'(commitAllow), 32'd0);
    check("reset fwdValid", 11, 32'(fwdValid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      runStep(VEC[i][35:34], VEC[i][33:15], VEC[i][14:7],
              VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end

    // R10: load in the same clock as an accepted start is dropped
    runStep(OP_LOAD,  19'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 10);
    runStep(OP_LOAD,  19'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 10);
    runStep(OP_LOAD,  19'h05555, 8'hA0, 1'b0, 1'b1, 1'b0, 10);
    runStep(OP_START, 19'h0, 8'h0,       1'b0, 1'b1, 1'b1, 10);
    runStep(OP_DONE,  19'h0, 8'h0,       1'b0, 1'b1, 1'b0, 10);
    runStep(OP_LOAD,  19'h05555, 8'hAA, 1'b0, 1'b1, 1'b0, 10);
    runStep(OP_LOAD,  19'h02AAA, 8'h55, 1'b0, 1'b1, 1'b0, 10);
    runStep(OP_BOTH,  19'h05555, 8'hA0, 1'b0, 1'b1, 1'b0, 10);
    runStep(OP_DONE,  19'h0, 8'h0,       1'b0, 1'b1, 1'b0, 10);

    // R11: ordinary reset keeps the flag but drops partial tracking
    runStep(OP_LOAD,  19'h05555, 8'hAA, 1'b0, 1'b1, 1'b0, 11);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("protectOn after rstN", 11, 32'(protectOn), 32'd1);
    runStep(OP_LOAD,  19'h02AAA, 8'h55, 1'b1, 1'b1, 1'b0, 11);
    runStep(OP_LOAD,  19'h05555, 8'hA0, 1'b1, 1'b1, 1'b0, 11);
    runStep(OP_START, 19'h0, 8'h0,       1'b0, 1'b1, 1'b0, 11);
    runStep(OP_DONE,  19'h0, 8'h0,       1'b0, 1'b1, 1'b0, 11);

    // R1: non-volatile reset returns the flag to the delivered state
    nvRstN = 1'b0;
    @(negedge clk);
    nvRstN = 1'b1;
    @(negedge clk);
    check("protectOn after nvRstN", 1, 32'(protectOn), 32'd0);
    runStep(OP_START, 19'h0, 8'h0, 1'b0, 1'b0, 1'b1, 1);
    runStep(OP_DONE,  19'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule